// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

This block models a synchronous static memory whose bus never needs a turnaround gap. Every rising clock edge can accept a new command, read or write, and the two kinds may alternate freely. A write presents its address and byte-lane mask first and delivers its data a fixed number of cycles later. That delay lines write data up with the slot that a read issued at the same time would use for its result.

A static timing input chooses between two latencies. In flow-through timing, read data leaves the array combinationally in the cycle after the address edge, and write data is taken one edge after its address. In pipelined timing, read data passes through an output register and appears one cycle later, and write data is taken two edges after its address. A read that targets a write still waiting for its data returns the newly arriving bytes, so reads after writes are coherent.

A four-beat burst begins with an ordinary command and continues with an advance input. Only the two low address bits step, in linear or interleaved order. The device is selected when three chip enables are all high. An asynchronous output enable and an asynchronous sleep input both force the drive flag low. Data in and data out use separate ports.

Top module: `lw_sram`

## Requirements
- R1: Commands are sampled on the rising clock edge, and a new command is accepted on every edge. Read and write commands may alternate on consecutive edges with no idle cycle between them.
- R2: With `pipe_mode`=0, a read sampled at edge t drives `rdata` with `drive`=1 during the cycle that follows edge t.
- R3: With `pipe_mode`=1, read data is registered and is driven during the cycle that follows edge t+1.
- R4: With `pipe_mode`=0, the data for a write sampled at edge t is taken from `wdata` at edge t+1. With `pipe_mode`=1, it is taken at edge t+2.
- R5: Writes are masked per byte lane. Bit i of `lane_we` enables data bits [9i+8:9i]. A lane whose bit is 0 keeps its stored value.
- R6: A command that is not an advance is accepted only when `ce_a`, `ce_b` and `ce_c` are all 1. Otherwise the cycle is a deselect, which performs no access and closes any open burst.
- R7: With `adv`=1 and a burst open, the block performs the next beat. The beat uses the read/write type of the burst start and the upper address bits of the start address. With `burst_ilv`=0, the two low bits are the start bits plus the beat number, modulo 4. An advance with no open burst performs no access.
- R8: With `burst_ilv`=1, the two low bits of beat n are the start bits XOR n.
- R9: In pipelined timing, a read issued one cycle after a write to the same address returns the write's data in the enabled lanes, and the stored data in the other lanes.
- R10: `oe`=0 forces `drive` low at once, without waiting for a clock edge.
- R11: While `sleep`=1, `drive` is low at once and any command sampled is ignored.
- R12: `rdata` is all zero whenever `drive` is 0. After reset, `drive` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | Static timing select: 1 pipelined, 0 flow-through |
| burst_ilv | input | 1 | Static burst order: 1 interleaved, 0 linear |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous power-down |
| ce_a | input | 1 | Chip enable 1 |
| ce_b | input | 1 | Chip enable 2 |
| ce_c | input | 1 | Chip enable 3 |
| adv | input | 1 | Continue the open burst |
| we | input | 1 | 1 write, 0 read (new commands only) |
| addr | input | ADDR_W | Command address |
| lane_we | input | LANES | Per-lane write enable, sampled with the command |
| wdata | input | LANES*LANE_W | Late write data |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| drive | output | 1 | Output drive flag |

## Verification
The bench uses the default parameters: two 9-bit lanes (18-bit words) and a 64-word array. The 9-bit lane boundary therefore shows up in the masked-write results. With six address bits, a burst can wrap its two low bits while the upper bits stay fixed. The table pass exercises flow-through timing, alternating reads and writes, chip-select and linear bursts. The directed passes cover interleaved order, asynchronous enable and sleep, and pipelined timing with forwarding on a partial-lane write.

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 6,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              burst_ilv,
  input  logic              oe,
  input  logic              sleep,
  input  logic              ce_a,
  input  logic              ce_b,
  input  logic              ce_c,
  input  logic              adv,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              drive
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  logic              b_act, b_we;
  logic [ADDR_W-1:0] b_base;
  logic [1:0]        b_beat;

  wire [1:0] nbeat = b_beat + 2'd1;
  wire [1:0] nlo   = burst_ilv ? (b_base[1:0] ^ nbeat) : (b_base[1:0] + nbeat);
  wire       sel   = ce_a & ce_b & ce_c;
  wire       start = !sleep && !adv && sel;
  wire       cont  = !sleep && adv && b_act;

  wire              c_we   = start ? we : b_we;
  wire [ADDR_W-1:0] c_addr = start ? addr : {b_base[ADDR_W-1:2], nlo};

  logic              s1_v, s1_we, s2_v, s2_we;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [LANES-1:0]  s1_l, s2_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_act <= 1'b0;
      s1_v  <= 1'b0;
      s2_v  <= 1'b0;
    end else begin
      if (start)              b_act <= 1'b1;
      else if (!sleep && !adv) b_act <= 1'b0;
      s1_v <= start || cont;
      s2_v <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      b_base <= addr;
      b_we   <= we;
      b_beat <= 2'd0;
    end else if (cont) begin
      b_beat <= nbeat;
    end
    s1_we <= c_we;
    s1_a  <= c_addr;
    s1_l  <= start ? lane_we : (cont ? lane_we : s1_l);
    s2_we <= s1_we;
    s2_a  <= s1_a;
    s2_l  <= s1_l;
  end

  wire              wv = pipe_mode ? (s2_v && s2_we) : (s1_v && s1_we);
  wire [ADDR_W-1:0] wa = pipe_mode ? s2_a : s1_a;
  wire [LANES-1:0]  wl = pipe_mode ? s2_l : s1_l;

  logic [DW-1:0] fwd;
  always_comb begin
    fwd = mem[s1_a];
    for (int i = 0; i < LANES; i++)
      if (wv && wa == s1_a && wl[i]) fwd[i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (wv && wl[i]) mem[wa][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
  end

  logic          q_v;
  logic [DW-1:0] q_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v <= 1'b0;
      q_d <= '0;
    end else begin
      q_v <= s1_v && !s1_we;
      q_d <= fwd;
    end
  end

  wire out_v = pipe_mode ? q_v : (s1_v && !s1_we);
  assign drive = out_v && oe && !sleep;
  assign rdata = drive ? (pipe_mode ? q_d : mem[s1_a]) : '0;
endmodule

module lw_sram_chk #(parameter int DW = 18) (
  input logic          clk,
  input logic          rst_n,
  input logic          pipe_mode,
  input logic          oe,
  input logic          sleep,
  input logic          ce_all,
  input logic          adv,
  input logic          we,
  input logic          drive,
  input logic [DW-1:0] rdata
);
  wire rd_new = !sleep && !adv && ce_all && !we;

  p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_n) !oe |-> !drive);
  p_sleep_off_r11: assert property (@(posedge clk) disable iff (!rst_n) sleep |-> !drive);
  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n) !drive |-> rdata == '0);
  p_flow_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && rd_new) |=> (drive || !oe || sleep || pipe_mode));
  p_pipe_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && rd_new) |=> ##1 (drive || !oe || sleep || !pipe_mode));
  p_desel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !adv && !ce_all) |=> (!drive || pipe_mode));
endmodule

bind lw_sram lw_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .oe(oe), .sleep(sleep),
  .ce_all(ce_a & ce_b & ce_c), .adv(adv), .we(we), .drive(drive), .rdata(rdata)
);

// File: tb/lw_sram_tb.sv
module lw_sram_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pipe_mode = 1'b0, burst_ilv = 1'b0, oe = 1'b1, sleep = 1'b0;
  logic [2:0] ce = 3'b000;
  logic adv = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [1:0] lane_we = 2'b11;
  logic [17:0] wdata = '0, rdata;
  logic drive;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  lw_sram u_dut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
    .oe(oe), .sleep(sleep), .ce_a(ce[0]), .ce_b(ce[1]), .ce_c(ce[2]),
    .adv(adv), .we(we), .addr(addr), .lane_we(lane_we), .wdata(wdata),
    .rdata(rdata), .drive(drive)
  );

  // adv, we, ce, addr, lanes, wdata, exp drive, exp rdata
  localparam int NV = 19;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 1'b1, 3'b111, 6'd4,  2'b11, 18'h00000, 1'b0, 18'h00000},
    {1'b0, 1'b1, 3'b111, 6'd5,  2'b11, 18'h12345, 1'b0, 18'h00000},
    {1'b0, 1'b0, 3'b111, 6'd4,  2'b11, 18'h0ABCD, 1'b1, 18'h12345},
    {1'b0, 1'b0, 3'b111, 6'd5,  2'b11, 18'h00000, 1'b1, 18'h0ABCD},
    {1'b0, 1'b1, 3'b111, 6'd5,  2'b01, 18'h00000, 1'b0, 18'h00000},
    {1'b0, 1'b0, 3'b111, 6'd5,  2'b11, 18'h3FFFF, 1'b1, 18'h0ABFF},
    {1'b0, 1'b0, 3'b011, 6'd4,  2'b11, 18'h00000, 1'b0, 18'h00000},
    {1'b0, 1'b0, 3'b110, 6'd4,  2'b11, 18'h00000, 1'b0, 18'h00000},
    {1'b0, 1'b0, 3'b111, 6'd4,  2'b11, 18'h00000, 1'b1, 18'h12345},
    {1'b0, 1'b1, 3'b111, 6'd9,  2'b11, 18'h00000, 1'b0, 18'h00000},
    {1'b1, 1'b0, 3'b000, 6'd0,  2'b11, 18'h00001, 1'b0, 18'h00000},
    {1'b1, 1'b0, 3'b000, 6'd0,  2'b11, 18'h00002, 1'b0, 18'h00000},
    {1'b1, 1'b0, 3'b000, 6'd0,  2'b11, 18'h00003, 1'b0, 18'h00000},
    {1'b0, 1'b0, 3'b111, 6'd11, 2'b11, 18'h00004, 1'b1, 18'h00003},
    {1'b1, 1'b0, 3'b000, 6'd0,  2'b11, 18'h00000, 1'b1, 18'h00004},
    {1'b1, 1'b0, 3'b000, 6'd0,  2'b11, 18'h00000, 1'b1, 18'h00001},
    {1'b1, 1'b0, 3'b000, 6'd0,  2'b11, 18'h00000, 1'b1, 18'h00002},
    {1'b0, 1'b0, 3'b000, 6'd0,  2'b11, 18'h00000, 1'b0, 18'h00000},
    {1'b1, 1'b0, 3'b000, 6'd0,  2'b11, 18'h00000, 1'b0, 18'h00000}
  };

  task automatic chk(input string req, input logic ed, input logic [17:0] er);
    checks++;
    if (drive !== ed || rdata !== er) begin
      fails++;
      $display("FAIL %s: drive=%b rdata=%h expected drive=%b rdata=%h", req, drive, rdata, ed, er);
    end
  endtask

  task automatic cyc(input logic a, input logic w, input logic [2:0] c, input logic [5:0] ad,
                     input logic [1:0] l, input logic [17:0] d);
    adv = a; we = w; ce = c; addr = ad; lane_we = l; wdata = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset", 1'b0, 18'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // flow-through table: R1 R2 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][49], VEC[i][48], VEC[i][47:45], VEC[i][44:39], VEC[i][38:37], VEC[i][36:19]);
      chk($sformatf("R1/R2/R4/R5/R6/R7 row %0d", i), VEC[i][18], VEC[i][17:0]);
    end

    // R8 interleaved read burst from 9: 9, 8, 11, 10
    burst_ilv = 1'b1;
    cyc(1'b0, 1'b0, 3'b111, 6'd9, 2'b11, 18'h0); chk("R8 beat0", 1'b1, 18'h00001);
    cyc(1'b1, 1'b0, 3'b000, 6'd0, 2'b11, 18'h0); chk("R8 beat1", 1'b1, 18'h00004);
    cyc(1'b1, 1'b0, 3'b000, 6'd0, 2'b11, 18'h0); chk("R8 beat2", 1'b1, 18'h00003);
    cyc(1'b1, 1'b0, 3'b000, 6'd0, 2'b11, 18'h0); chk("R8 beat3", 1'b1, 18'h00002);
    cyc(1'b0, 1'b0, 3'b000, 6'd0, 2'b11, 18'h0);
    burst_ilv = 1'b0;

    // R10 asynchronous output enable
    oe = 1'b0;
    cyc(1'b0, 1'b0, 3'b111, 6'd4, 2'b11, 18'h0); chk("R10 oe low", 1'b0, 18'h0);
    oe = 1'b1; #1; chk("R10 oe rises mid-cycle", 1'b1, 18'h12345);

    // R11 sleep drops a write and kills drive at once
    sleep = 1'b1;
    cyc(1'b0, 1'b1, 3'b111, 6'd4, 2'b11, 18'h0); chk("R11 asleep", 1'b0, 18'h0);
    sleep = 1'b0;
    cyc(1'b0, 1'b0, 3'b111, 6'd4, 2'b11, 18'h3FFFF); chk("R11 write ignored", 1'b1, 18'h12345);
    sleep = 1'b1; #1; chk("R11 sleep mid-cycle", 1'b0, 18'h0);
    sleep = 1'b0;
    cyc(1'b0, 1'b0, 3'b000, 6'd0, 2'b11, 18'h0);
    cyc(1'b0, 1'b0, 3'b000, 6'd0, 2'b11, 18'h0);

    // pipelined timing: R3 R4 R9
    pipe_mode = 1'b1;
    cyc(1'b0, 1'b1, 3'b111, 6'd20, 2'b11, 18'h0);     chk("R3 after write", 1'b0, 18'h0);
    cyc(1'b0, 1'b0, 3'b111, 6'd20, 2'b11, 18'h0);     chk("R3 one edge latency", 1'b0, 18'h0);
    cyc(1'b0, 1'b1, 3'b111, 6'd20, 2'b10, 18'h2AAAA); chk("R9 R4 forwarded full word", 1'b1, 18'h2AAAA);
    cyc(1'b0, 1'b0, 3'b111, 6'd20, 2'b11, 18'h0);     chk("R3 write slot", 1'b0, 18'h0);
    cyc(1'b0, 1'b0, 3'b000, 6'd0,  2'b11, 18'h0);     chk("R9 R5 forwarded lane1", 1'b1, 18'h000AA);
    cyc(1'b0, 1'b0, 3'b111, 6'd20, 2'b11, 18'h0);     chk("R3 idle then read", 1'b0, 18'h0);
    cyc(1'b0, 1'b0, 3'b000, 6'd0,  2'b11, 18'h0);     chk("R3 stored data", 1'b1, 18'h000AA);
    cyc(1'b0, 1'b0, 3'b000, 6'd0,  2'b11, 18'h0);     chk("R12 idle zero", 1'b0, 18'h0);

    summary();
  end
endmodule